// File: doc/BRIEF.md
# Dual-Mode Shift Register with Mode-Selected Clocks

This block is a parameterised register, four stages wide by default, with two working modes. In shift mode the contents move one stage toward the higher index and a serial bit enters the lowest stage. In load mode every stage takes its own parallel input at the same moment. Each mode has its own clock input, and the mode input picks which of the two clocks advances the register. Only the falling edge of the selected clock causes an update.

The two mode clocks are not used as real clocks. A free-running system clock samples them through a short synchronizer. A detected falling edge on the selected clock becomes a one-cycle update enable. A shift toward the lower index is not built in. It is obtained in load mode by wiring each stage output to the parallel input of the stage below it and feeding new serial data into the top parallel input. The outputs of all stages are visible at all times.

Top module: `dual_mode_shreg`

## Requirements
- R1: While rst_ni is low, q_o is all zeros.
- R2: With mode_i = 0, a falling edge on shift_clk_i makes q_o[0] take ser_i and each q_o[k] take the old q_o[k-1].
- R3: With mode_i = 0, edges on load_clk_i and any value on par_i leave q_o unchanged.
- R4: With mode_i = 1, a falling edge on load_clk_i makes q_o take par_i, all bits together.
- R5: With mode_i = 1, edges on shift_clk_i and any value on ser_i leave q_o unchanged.
- R6: A rising edge on either mode clock leaves q_o unchanged. Only falling edges update the register.
- R7: A change of mode_i takes effect at the next falling edge of the newly selected clock. The result shows on q_o within SYNC_STAGES+1 system clock cycles after that edge.
- R8: With mode_i = 1 and par_i[k] wired to q_o[k+1] for k < WIDTH-1, and par_i[WIDTH-1] driven by new data, each falling edge on load_clk_i shifts q_o toward index 0 and puts the new data in the top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 0 = shift on shift_clk_i, 1 = load on load_clk_i |
| shift_clk_i | input | 1 | Clock for shift mode, acts on its falling edge |
| load_clk_i | input | 1 | Clock for load mode, acts on its falling edge |
| ser_i | input | 1 | Serial data into stage 0 |
| par_i | input | WIDTH | Parallel data, one bit per stage |
| q_o | output | WIDTH | Stage outputs, bit 0 is the first stage |

## Verification
The register is driven with random sequences of mode, serial bit, parallel word and the choice of which clock to pulse. This shows whether the enable follows the selected clock and not the other one. Directed cases raise a clock without lowering it, to separate rising-edge from falling-edge behaviour. They also switch mode and then pulse the clock that is now deselected, to show whether a mode change arms the right clock. A phase with the outputs fed back into the parallel inputs checks the left shift against a model. That phase also exposes any bit-order error in the load path, which plain parallel loads of symmetric words might hide.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic {
    MODE_SHIFT = 1'b0,
    MODE_LOAD  = 1'b1
  } shreg_mode_e;
endpackage

// File: rtl/shreg_sync.sv
module shreg_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q[s] <= '0;
      end else if (s == 0) begin
        chain_q[s] <= d_i;
      end else begin
        chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/shreg_fall_det.sv
module shreg_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);
  logic prev_q;

  // reset low so a clock held high at reset release gives no spurious edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/shreg_stage.sv
module shreg_stage
  import shreg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        upd_i,
  input  shreg_mode_e mode_i,
  input  logic        chain_i,
  input  logic        par_i,
  output logic        q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= 1'b0;
    end else if (upd_i) begin
      q_o <= (mode_i == MODE_LOAD) ? par_i : chain_i;
    end
  end
endmodule

// File: rtl/dual_mode_shreg.sv
module dual_mode_shreg
  import shreg_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             shift_clk_i,
  input  logic             load_clk_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int CtlW = 3;

  logic [CtlW-1:0] ctl_s;
  logic            mode_s, shift_s, load_s;
  logic            shift_fall, load_fall, upd;
  shreg_mode_e     mode_e;

  // mode goes through the same synchronizer so it lines up with the clocks
  shreg_sync #(.WIDTH(CtlW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({mode_i, load_clk_i, shift_clk_i}),
    .q_o   (ctl_s)
  );

  assign shift_s = ctl_s[0];
  assign load_s  = ctl_s[1];
  assign mode_s  = ctl_s[2];
  assign mode_e  = shreg_mode_e'(mode_s);

  shreg_fall_det u_fall_shift (
    .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(shift_s), .fall_o(shift_fall)
  );
  shreg_fall_det u_fall_load (
    .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(load_s), .fall_o(load_fall)
  );

  assign upd = (mode_e == MODE_LOAD) ? load_fall : shift_fall;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic chain_in;
    if (i == 0) begin : g_head
      assign chain_in = ser_i;
    end else begin : g_body
      assign chain_in = q_o[(i == 0) ? 0 : i-1];
    end
    shreg_stage u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .upd_i  (upd),
      .mode_i (mode_e),
      .chain_i(chain_in),
      .par_i  (par_i[i]),
      .q_o    (q_o[i])
    );
  end
endmodule

// File: rtl/shreg_checker.sv
module shreg_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_s,
  input logic             shift_fall,
  input logic             load_fall,
  input logic             ser_i,
  input logic [WIDTH-1:0] par_i,
  input logic [WIDTH-1:0] q_o
);
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> q_o == '0);

  assert_right_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_fall && !mode_s) |=> q_o == {$past(q_o[WIDTH-2:0]), $past(ser_i)});

  assert_par_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_fall && mode_s) |=> q_o == $past(par_i));

  // R3 R5: the deselected clock never moves the register
  assert_hold_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((shift_fall && !mode_s) || (load_fall && mode_s)) |=> $stable(q_o));

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_fall || load_fall) |=> !($past(shift_fall) && shift_fall) && !($past(load_fall) && load_fall));
endmodule

bind dual_mode_shreg shreg_checker #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_s    (mode_s),
  .shift_fall(shift_fall),
  .load_fall (load_fall),
  .ser_i     (ser_i),
  .par_i     (par_i),
  .q_o       (q_o)
);

// File: tb/dual_mode_shreg_tb.sv
module dual_mode_shreg_tb;
  localparam int W = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         mode_i = 1'b0;
  logic         shift_clk_i = 1'b0;
  logic         load_clk_i = 1'b0;
  logic         ser_i = 1'b0;
  logic [W-1:0] par_reg = '0;
  logic         wire_left = 1'b0;
  logic [W-1:0] par_i;
  logic [W-1:0] q_o;
  logic [W-1:0] exp_q = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  assign par_i = wire_left ? {ser_i, q_o[W-1:1]} : par_reg;

  dual_mode_shreg #(.WIDTH(W), .SYNC_STAGES(2)) u_dut (
    .clk_i, .rst_ni, .mode_i, .shift_clk_i, .load_clk_i, .ser_i, .par_i, .q_o
  );

  function automatic logic [W-1:0] model_shift(logic [W-1:0] q, logic s);
    return {q[W-2:0], s};
  endfunction
  function automatic logic [W-1:0] model_left(logic [W-1:0] q, logic s);
    return {s, q[W-1:1]};
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: q_o=%b expected %b", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic pulse_shift();
    shift_clk_i = 1'b1; wait_n(5);
    shift_clk_i = 1'b0; wait_n(5);
  endtask
  task automatic pulse_load();
    load_clk_i = 1'b1; wait_n(5);
    load_clk_i = 1'b0; wait_n(5);
  endtask

  initial begin
    void'($urandom(32'd2024));
    wait_n(3);
    chk("R1 reset", q_o, '0);
    rst_ni = 1'b1; wait_n(2);
    chk("R1 after release", q_o, '0);

    // directed R2: shift in 1,0,1,1
    mode_i = 1'b0; wait_n(4);
    ser_i = 1'b1; pulse_shift(); exp_q = model_shift(exp_q, 1'b1); chk("R2 shift", q_o, exp_q);
    ser_i = 1'b0; pulse_shift(); exp_q = model_shift(exp_q, 1'b0); chk("R2 shift", q_o, exp_q);
    ser_i = 1'b1; pulse_shift(); exp_q = model_shift(exp_q, 1'b1); chk("R2 shift", q_o, exp_q);

    // R3: load clock and par_i ignored in shift mode
    par_reg = 4'b0110; pulse_load(); chk("R3 load clk ignored", q_o, exp_q);

    // R6: rising edge alone has no effect, falling edge then acts
    ser_i = 1'b1; shift_clk_i = 1'b1; wait_n(6);
    chk("R6 rising ignored", q_o, exp_q);
    shift_clk_i = 1'b0; wait_n(5);
    exp_q = model_shift(exp_q, 1'b1); chk("R6 falling acts", q_o, exp_q);

    // R7/R4: switch to load, old clock now inert, new clock acts
    mode_i = 1'b1; wait_n(4);
    ser_i = 1'b0; pulse_shift(); chk("R7 R5 shift clk inert", q_o, exp_q);
    par_reg = 4'b1001; pulse_load(); exp_q = 4'b1001; chk("R4 load", q_o, exp_q);
    par_reg = 4'b0100; pulse_load(); exp_q = 4'b0100; chk("R4 load", q_o, exp_q);

    // R7 latency: update visible within SYNC_STAGES+1 cycles
    par_reg = 4'b1110; load_clk_i = 1'b1; wait_n(5);
    load_clk_i = 1'b0; wait_n(3); exp_q = 4'b1110;
    chk("R7 latency", q_o, exp_q);
    wait_n(3);

    // R8: external feedback gives left shift
    wire_left = 1'b1;
    for (int i = 0; i < 8; i++) begin
      ser_i = 1'($urandom_range(0, 1));
      pulse_load();
      exp_q = model_left(exp_q, ser_i);
      chk("R8 left shift", q_o, exp_q);
    end
    wire_left = 1'b0;

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic m, which;
      m = 1'($urandom_range(0, 1));
      which = 1'($urandom_range(0, 1));
      mode_i = m; wait_n(4);
      ser_i = 1'($urandom_range(0, 1));
      par_reg = W'($urandom_range(0, 15));
      if (which) pulse_load(); else pulse_shift();
      if (!m && !which) begin
        exp_q = model_shift(exp_q, ser_i); chk("R2 random shift", q_o, exp_q);
      end else if (m && which) begin
        exp_q = par_reg; chk("R4 random load", q_o, exp_q);
      end else if (!m) begin
        chk("R3 random hold", q_o, exp_q);
      end else begin
        chk("R5 random hold", q_o, exp_q);
      end
    end

    // mid-run reset
    rst_ni = 1'b0; wait_n(2);
    exp_q = '0; chk("R1 mid reset", q_o, exp_q);
    rst_ni = 1'b1; wait_n(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: q_o=%b expected completion", q_o);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule